// File: doc/BRIEF.md
# Descriptor-driven CRC32C checksum engine

The engine sits on a byte-wide DMA data path and computes a CRC32C over the payload of each transfer. A transfer is opened by a descriptor that gives the payload length in bytes, an optional 32-bit seed, the mode bits and the address fields. The payload then arrives on a valid/ready byte stream. In copy mode each payload byte is passed through to an output stream. In checksum-only mode the payload is consumed and nothing is forwarded.

A descriptor with neither store nor test set only folds its payload into a running CRC. The next descriptor continues from that value, so one result can cover several chunks. A store descriptor closes the chain and emits the final value. The value goes either onto the output stream as four bytes after the payload or onto a separate result port. A test descriptor closes the chain and compares the final value against an expected value. The expected value is either taken from four trailing bytes on the input stream or supplied with the descriptor. Descriptors with illegal mode combinations or out-of-range addresses are rejected.

Every descriptor ends with a one-cycle done pulse. The mismatch and reject flags are valid in that cycle. The next descriptor is taken only after the done pulse.

Top module: `crc_desc_engine`

## Requirements
- R1: The checksum is the reflected CRC32C with polynomial 0x82F63B78. It processes one byte per accepted payload beat, least significant bit first. The register starts a chain at 0xFFFFFFFF, and the reported value is the register XOR 0xFFFFFFFF, so the nine ASCII bytes "123456789" give 0xE3069283.
- R2: A descriptor with store=0, test=0 and inline=0 gives a done pulse with no result, no mismatch and no reject. The next descriptor continues from the CRC register it left behind.
- R3: With store=1 and inline=0, res_valid_o is high with done_o, and res_data_o carries the final CRC.
- R4: With store=1 and inline=1, the final CRC follows the payload on the output stream as four bytes in wire order, bits 7:0 first. This applies in copy mode and in checksum-only mode, and done_o pulses after the fourth byte is taken.
- R5: With test=1 and inline=0, err_mismatch_o is high with done_o exactly when the final CRC differs from desc_expect_i.
- R6: With test=1 and inline=1, four more input bytes are consumed after the payload and form the expected value, bits 7:0 first. These bytes are not counted in the length, not folded into the CRC and not forwarded. A mismatch is flagged as in R5.
- R7: With use_seed=1, the CRC register is loaded with desc_seed_i before that descriptor's payload, whatever the chain held before.
- R8: A descriptor with store=1 and test=1 is rejected. It gives a done pulse with err_reject_o the cycle after acceptance, consumes no payload and leaves the running CRC and the chain state unchanged.
- R9: A descriptor with inline=1 and neither store nor test is rejected in the same way as R8.
- R10: A descriptor is rejected when bits 63:40 are not all zero in any of these fields: the source address, the destination address in copy mode only, or the result address when inline=0.
- R11: In copy mode the payload bytes appear on the output stream in order, under output backpressure. In checksum-only mode the output stream carries only the bytes of R4.
- R12: desc_ready_o is high only when the engine is idle. done_o is a single-cycle pulse, and a new descriptor is accepted after it.
- R13: After a store or test descriptor, the next descriptor without a seed starts again from 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor valid |
| desc_ready_o | output | 1 | Engine idle, descriptor can be taken |
| desc_len_i | input | LEN_W | Payload length in bytes |
| desc_seed_i | input | 32 | Seed value |
| desc_use_seed_i | input | 1 | Load the seed before the payload |
| desc_store_i | input | 1 | Close the chain and emit the result |
| desc_test_i | input | 1 | Close the chain and compare the result |
| desc_inline_i | input | 1 | Result or expected value travels in the byte stream |
| desc_copy_i | input | 1 | Forward the payload to the output stream |
| desc_src_addr_i | input | ADDR_W | Source address, range checked |
| desc_dst_addr_i | input | ADDR_W | Destination address, checked in copy mode |
| desc_res_addr_i | input | ADDR_W | Result address, checked when inline is clear |
| desc_expect_i | input | 32 | Expected CRC for an out-of-band test |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Input byte accepted |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Output byte taken downstream |
| res_valid_o | output | 1 | Out-of-band result valid, with done |
| res_data_o | output | 32 | Final CRC |
| done_o | output | 1 | One-cycle end-of-descriptor pulse |
| err_mismatch_o | output | 1 | Test failed, with done |
| err_reject_o | output | 1 | Descriptor rejected, with done |

## Verification
A corrupted CRC register or a wrong chain-start flag is invisible during accumulate descriptors. It shows up only at the next store or test. There it appears as a wrong res_data_o value, a wrong trailing byte on the output stream or a spurious err_mismatch_o, one cycle after the last payload or trailing byte. A stuck phase or byte counter shows as a missing or extra output byte, or as a done pulse that comes early or never comes. A reject path that touches state shows as a wrong result on the descriptor after the rejected one.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int unsigned CRC_W     = 32;
  localparam logic [31:0] CRC_POLY  = 32'h82F63B78;
  localparam logic [31:0] CRC_INIT  = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_XOUT  = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_TRAIL, ST_APPEND, ST_DONE
  } state_e;

  typedef struct packed {
    logic use_seed;
    logic store;
    logic test;
    logic inl;
    logic copy;
  } mode_t;
endpackage

// File: rtl/crc32c_byte.sv
module crc32c_byte #(
  parameter logic [31:0] POLY = crc_eng_pkg::CRC_POLY
) (
  input  logic [31:0] crc_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  always_comb begin
    logic [31:0] c;
    c = crc_i ^ {24'd0, byte_i};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
    end
    crc_o = c;
  end
endmodule

// File: rtl/desc_check.sv
module desc_check #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned ADDR_HI_W = 24
) (
  input  crc_eng_pkg::mode_t mode_i,
  input  logic [ADDR_W-1:0]  src_i,
  input  logic [ADDR_W-1:0]  dst_i,
  input  logic [ADDR_W-1:0]  res_i,
  output logic               reject_o
);
  localparam int unsigned LO = ADDR_W - ADDR_HI_W;

  logic src_bad, dst_bad, res_bad, mode_bad;

  assign src_bad  = |src_i[ADDR_W-1:LO];
  assign dst_bad  = mode_i.copy & (|dst_i[ADDR_W-1:LO]);
  assign res_bad  = ~mode_i.inl & (|res_i[ADDR_W-1:LO]);
  assign mode_bad = (mode_i.store & mode_i.test) |
                    (mode_i.inl & ~mode_i.store & ~mode_i.test);
  assign reject_o = src_bad | dst_bad | res_bad | mode_bad;
endmodule

// File: rtl/crc_desc_engine.sv
module crc_desc_engine
  import crc_eng_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned ADDR_HI_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [LEN_W-1:0]  desc_len_i,
  input  logic [31:0]       desc_seed_i,
  input  logic              desc_use_seed_i,
  input  logic              desc_store_i,
  input  logic              desc_test_i,
  input  logic              desc_inline_i,
  input  logic              desc_copy_i,
  input  logic [ADDR_W-1:0] desc_src_addr_i,
  input  logic [ADDR_W-1:0] desc_dst_addr_i,
  input  logic [ADDR_W-1:0] desc_res_addr_i,
  input  logic [31:0]       desc_expect_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  input  logic              out_ready_i,
  output logic              res_valid_o,
  output logic [31:0]       res_data_o,
  output logic              done_o,
  output logic              err_mismatch_o,
  output logic              err_reject_o
);
  state_e            state_q;
  mode_t             mode_q, mode_in;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [31:0]       crc_q, crc_step, fin;
  logic [31:0]       exp_q;
  logic [1:0]        tail_q;
  logic              fresh_q, rej_q, reject;
  logic              desc_fire, in_fire, out_fire, last_beat;

  assign mode_in = '{use_seed: desc_use_seed_i, store: desc_store_i,
                     test: desc_test_i, inl: desc_inline_i, copy: desc_copy_i};

  desc_check #(.ADDR_W(ADDR_W), .ADDR_HI_W(ADDR_HI_W)) u_check (
    .mode_i   (mode_in),
    .src_i    (desc_src_addr_i),
    .dst_i    (desc_dst_addr_i),
    .res_i    (desc_res_addr_i),
    .reject_o (reject)
  );

  crc32c_byte #(.POLY(CRC_POLY)) u_step (
    .crc_i  (crc_q),
    .byte_i (in_data_i),
    .crc_o  (crc_step)
  );

  function automatic state_e after_data(mode_t m);
    if (m.test && m.inl)       return ST_TRAIL;
    else if (m.store && m.inl) return ST_APPEND;
    else                       return ST_DONE;
  endfunction

  assign fin          = crc_q ^ CRC_XOUT;
  assign desc_ready_o = (state_q == ST_IDLE);
  assign desc_fire    = desc_valid_i & desc_ready_o;

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = in_data_i;
    unique case (state_q)
      ST_DATA: begin
        in_ready_o  = mode_q.copy ? out_ready_i : 1'b1;
        out_valid_o = in_valid_i & mode_q.copy;
      end
      ST_TRAIL:  in_ready_o = 1'b1;
      ST_APPEND: begin
        out_valid_o = 1'b1;
        out_data_o  = fin[8*tail_q +: 8];
      end
      default: ;
    endcase
  end

  assign in_fire   = in_valid_i & in_ready_o;
  assign out_fire  = out_valid_o & out_ready_i;
  assign last_beat = ((cnt_q + LEN_W'(1)) == len_q);

  assign done_o         = (state_q == ST_DONE);
  assign err_reject_o   = done_o & rej_q;
  assign res_valid_o    = done_o & ~rej_q & mode_q.store & ~mode_q.inl;
  assign res_data_o     = fin;
  assign err_mismatch_o = done_o & ~rej_q & mode_q.test & (fin != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      crc_q   <= CRC_INIT;
      exp_q   <= '0;
      tail_q  <= '0;
      fresh_q <= 1'b1;
      rej_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (desc_fire) begin
          rej_q <= reject;
          if (reject) begin
            state_q <= ST_DONE;
          end else begin
            mode_q <= mode_in;
            len_q  <= desc_len_i;
            cnt_q  <= '0;
            tail_q <= '0;
            exp_q  <= desc_expect_i;
            if (desc_use_seed_i) crc_q <= desc_seed_i;
            else if (fresh_q)    crc_q <= CRC_INIT;
            state_q <= (desc_len_i == '0) ? after_data(mode_in) : ST_DATA;
          end
        end
        ST_DATA: if (in_fire) begin
          crc_q <= crc_step;
          cnt_q <= cnt_q + LEN_W'(1);
          if (last_beat) state_q <= after_data(mode_q);
        end
        ST_TRAIL: if (in_fire) begin
          exp_q[8*tail_q +: 8] <= in_data_i;
          tail_q <= tail_q + 2'd1;
          if (tail_q == 2'd3) state_q <= ST_DONE;
        end
        ST_APPEND: if (out_fire) begin
          tail_q <= tail_q + 2'd1;
          if (tail_q == 2'd3) state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (!rej_q) fresh_q <= mode_q.store | mode_q.test;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crc_desc_engine_chk.sv
module crc_desc_engine_chk
  import crc_eng_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       desc_valid_i,
  input logic       desc_ready_o,
  input logic       desc_store_i,
  input logic       desc_test_i,
  input logic       desc_inline_i,
  input logic       done_o,
  input logic       res_valid_o,
  input logic       err_mismatch_o,
  input logic       err_reject_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input state_e     state_q
);
  logic fire;
  assign fire = desc_valid_i & desc_ready_o;

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_busy_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !desc_ready_o);
  a_r8_both_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && desc_store_i && desc_test_i) |=> (done_o && err_reject_o));
  a_r9_lone_inline_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && desc_inline_i && !desc_store_i && !desc_test_i) |=> (done_o && err_reject_o));
  a_r3_result_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> done_o);
  a_r5_mismatch_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_mismatch_o |-> done_o);
  a_r8_reject_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({res_valid_o, err_mismatch_o, err_reject_o}));
  a_r4_append_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_APPEND && out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  a_r6_trail_not_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRAIL) |-> !out_valid_o);
endmodule

bind crc_desc_engine crc_desc_engine_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .desc_valid_i   (desc_valid_i),
  .desc_ready_o   (desc_ready_o),
  .desc_store_i   (desc_store_i),
  .desc_test_i    (desc_test_i),
  .desc_inline_i  (desc_inline_i),
  .done_o         (done_o),
  .res_valid_o    (res_valid_o),
  .err_mismatch_o (err_mismatch_o),
  .err_reject_o   (err_reject_o),
  .out_valid_o    (out_valid_o),
  .out_ready_i    (out_ready_i),
  .out_data_o     (out_data_o),
  .state_q        (state_q)
);

// File: tb/crc_desc_engine_test.sv
module crc_desc_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic desc_valid_i = 1'b0, desc_ready_o;
  logic [15:0] desc_len_i = '0;
  logic [31:0] desc_seed_i = '0, desc_expect_i = '0;
  logic desc_use_seed_i = 0, desc_store_i = 0, desc_test_i = 0, desc_inline_i = 0, desc_copy_i = 0;
  logic [63:0] desc_src_addr_i = '0, desc_dst_addr_i = '0, desc_res_addr_i = '0;
  logic in_valid_i = 1'b0, in_ready_o;
  logic [7:0] in_data_i = '0;
  logic out_valid_o, out_ready_i = 1'b1;
  logic [7:0] out_data_o;
  logic res_valid_o, done_o, err_mismatch_o, err_reject_o;
  logic [31:0] res_data_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  crc_desc_engine uut (.*);

  int checks = 0, fails = 0;
  int dones_seen = 0, dones_pushed = 0;
  logic [7:0]  exp_out_q[$];
  string       out_tag_q[$];
  logic [34:0] exp_done_q[$];
  string       done_tag_q[$];
  logic [31:0] last_res;
  logic [7:0]  pl[64];
  logic [31:0] m_crc = 32'hFFFFFFFF;
  logic        m_fresh = 1'b1;
  bit          bp_mode = 0;
  int          cyc = 0;

  function automatic logic [31:0] step(logic [31:0] c, logic [7:0] b);
    c ^= {24'd0, b};
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
    return c;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  initial forever begin
    @(posedge clk_i); #1;
    cyc++;
    out_ready_i = !bp_mode || (cyc % 3 != 0);
  end

  initial forever begin
    @(negedge clk_i);
    if (rst_ni && out_valid_o && out_ready_i) begin
      if (exp_out_q.size() == 0) check("R11 unexpected output byte", {56'd0, out_data_o}, 64'hxx);
      else check(out_tag_q.pop_front(), {56'd0, out_data_o}, {56'd0, exp_out_q.pop_front()});
    end
    if (rst_ni && done_o) begin
      logic [34:0] act;
      act = {res_valid_o, res_valid_o ? res_data_o : 32'd0, err_mismatch_o, err_reject_o};
      if (res_valid_o) last_res = res_data_o;
      if (exp_done_q.size() == 0) check("R12 unexpected done", {29'd0, act}, 64'hxx);
      else check(done_tag_q.pop_front(), {29'd0, act}, {29'd0, exp_done_q.pop_front()});
      dones_seen++;
    end
  end

  task automatic send_byte(logic [7:0] b);
    in_valid_i = 1'b1; in_data_i = b;
    do @(negedge clk_i); while (!in_ready_o);
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
  endtask

  task automatic issue(int n, logic [31:0] seed, logic us, logic st, logic te, logic inl, logic cp,
                       logic [63:0] src, logic [63:0] dst, logic [63:0] res,
                       logic [31:0] expv, logic [31:0] trail, string tag);
    logic rej;
    logic [31:0] c, fin;
    logic mis;
    rej = (st & te) | (inl & !st & !te) | (src[63:40] != 0) |
          (cp & (dst[63:40] != 0)) | (!inl & (res[63:40] != 0));
    if (rej) begin
      exp_done_q.push_back({1'b0, 32'd0, 1'b0, 1'b1});
    end else begin
      c = us ? seed : (m_fresh ? 32'hFFFFFFFF : m_crc);
      for (int i = 0; i < n; i++) begin
        c = step(c, pl[i]);
        if (cp) begin exp_out_q.push_back(pl[i]); out_tag_q.push_back({tag, " R11 payload"}); end
      end
      fin = c ^ 32'hFFFFFFFF;
      if (st && inl)
        for (int k = 0; k < 4; k++) begin
          exp_out_q.push_back(fin[8*k +: 8]); out_tag_q.push_back({tag, " R4 inline byte"});
        end
      mis = te & (fin != (inl ? trail : expv));
      exp_done_q.push_back({st & !inl, (st & !inl) ? fin : 32'd0, mis, 1'b0});
      m_crc = c; m_fresh = st | te;
    end
    done_tag_q.push_back({tag, " done"});
    dones_pushed++;
    desc_len_i = 16'(n); desc_seed_i = seed; desc_use_seed_i = us; desc_store_i = st;
    desc_test_i = te; desc_inline_i = inl; desc_copy_i = cp; desc_src_addr_i = src;
    desc_dst_addr_i = dst; desc_res_addr_i = res; desc_expect_i = expv;
    desc_valid_i = 1'b1;
    do @(negedge clk_i); while (!desc_ready_o);
    @(posedge clk_i); #1;
    desc_valid_i = 1'b0;
    if (!rej) begin
      for (int i = 0; i < n; i++) send_byte(pl[i]);
      if (te && inl) for (int k = 0; k < 4; k++) send_byte(trail[8*k +: 8]);
    end
    wait (dones_seen == dones_pushed);
    @(posedge clk_i); #1;
  endtask

  function automatic logic [31:0] model_of(int n, logic [31:0] start);
    logic [31:0] c = start;
    for (int i = 0; i < n; i++) c = step(c, pl[i]);
    return c ^ 32'hFFFFFFFF;
  endfunction

  localparam logic [63:0] HI = 64'h0000_0100_0000_0000;

  initial begin
    logic [31:0] good;
    for (int i = 0; i < 64; i++) pl[i] = 8'(i * 37 + 11);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R12 reset desc_ready", {63'd0, desc_ready_o}, 64'd1);
    check("R12 reset outputs", {60'd0, out_valid_o, done_o, res_valid_o, err_reject_o}, 64'd0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 R3: known check value, checksum-only, out of band
    for (int i = 0; i < 9; i++) pl[i] = 8'h31 + 8'(i);
    issue(9, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 R3 check string");
    check("R1 CRC32C of 123456789", {32'd0, last_res}, {32'd0, 32'hE3069283});
    for (int i = 0; i < 64; i++) pl[i] = 8'(i * 37 + 11);

    // R2 R11 R4: copy-mode chain under backpressure, closed by inline store
    bp_mode = 1;
    issue(5, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R2 accumulate a");
    issue(3, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R2 accumulate b");
    issue(4, 0, 0, 1, 0, 1, 1, 0, 0, HI, 0, 0, "R4 copy inline store");
    // R4: checksum-only inline store
    issue(6, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R4 crc-only inline store");
    bp_mode = 0;

    // R5: out-of-band test, match and mismatch
    good = model_of(7, 32'hFFFFFFFF);
    issue(7, 0, 0, 0, 1, 0, 0, 0, 0, 0, good, 0, "R5 test match");
    issue(7, 0, 0, 0, 1, 0, 0, 0, 0, 0, good ^ 32'h1, 0, "R5 test mismatch");

    // R6: inline test, match (copy mode) and mismatch
    good = model_of(10, 32'hFFFFFFFF);
    issue(10, 0, 0, 0, 1, 1, 1, 0, 0, 0, 32'hDEAD_BEEF, good, "R6 inline test match");
    issue(10, 0, 0, 0, 1, 1, 0, 0, 0, 0, good, good ^ 32'h0100_0000, "R6 inline test mismatch");

    // R7: seed overrides accumulated state
    issue(4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 prior accumulate");
    issue(8, 32'h1234_5678, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7 seeded store");

    // R8 R9: rejects leave the chain untouched
    issue(5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 chain start");
    issue(5, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R8 store+test reject");
    issue(5, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R9 lone inline reject");
    issue(2, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 chain survives reject");

    // R10: address range rules
    issue(3, 0, 0, 1, 0, 0, 0, HI, 0, 0, 0, 0, "R10 src high reject");
    issue(3, 0, 0, 1, 0, 0, 1, 0, HI, 0, 0, 0, "R10 copy dst high reject");
    issue(3, 0, 0, 1, 0, 0, 0, 0, HI, 0, 0, 0, "R10 crc-only dst high accepted");
    issue(3, 0, 0, 1, 0, 0, 0, 0, 0, HI, 0, 0, "R10 res high reject");

    // R13: fresh chain after a closing descriptor; zero length
    issue(3, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R13 restart from init");
    issue(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R13 empty store");
    check("R13 empty chain result", {32'd0, last_res}, 64'd0);

    check("R11 output queue drained", 64'(exp_out_q.size()), 64'd0);
    check("R12 done queue drained", 64'(exp_done_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL R12 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule